// File: doc/BRIEF.md
# Serial Engine Run-State Controller

This block holds the run-state of a serial controller and lets software move it between reset, run and pause through a small register port. A state change does not take effect at once. The requested code first waits a fixed number of bus-clock cycles. It then goes to the serial-clock domain as a toggle, waits a fixed number of serial-clock cycles there, and returns as an acknowledge toggle. A valid flag reads low for the whole of that exchange. Software polls until valid is set and the state field holds the code it asked for.

Besides the state, the block keeps an operational status word. Four of its bits mirror live conditions from the datapath. Two of its bits are service flags that datapath events set and software clears by writing ones. A master-generator enable register reports readiness in the state register. A software-reset strobe returns everything to the reset state at once, and an exchange still in flight is abandoned cleanly. The run and pause enables drive the datapath.

Top module: `serial_run_ctrl`

## Requirements
- R1: The state field is bits [1:0] of the state register (word address 0), coded reset = 0, run = 1, pause = 3. Bit 2 of that register is valid and bit 4 is master-ready. After reset the register reads state 0 with valid set.
- R2: A write to address 0 with a legal code while valid is set is accepted. Valid reads low from the cycle after the write.
- R3: While a transition is in flight, the state field keeps the old code. Valid stays low for at least 3 bus cycles plus 3 serial cycles plus the crossing delay. The transition then completes with valid set and the field showing the requested code.
- R4: Writing a value with bit 0 set to address 1 forces state 0 and valid set in the next cycle, even during a transition. A later request still completes normally. Writing it with bit 0 clear has no effect.
- R5: Writing bit 0 of address 3 sets or clears the master-generator enable. Bit 4 of the state register reads it from the next cycle. A software reset clears it.
- R6: In the operational word (address 2), bit 8 (output service) and bit 9 (input service) are set by their event inputs. Writing 1 to a bit clears it, and writing 0 leaves it unchanged. An event wins over a clear in the same cycle.
- R7: Operational bits 3 (NACK), 4 (output not empty), 5 (input not empty) and 6 (output full) follow their inputs.
- R8: A write of code 2 to address 0 is ignored: state and valid are unchanged.
- R9: A state request made while valid is low is dropped. The transition in flight completes with its own code.
- R10: The run enable is high only when the state has settled at run with valid set. The pause enable is high only when it has settled at pause with valid set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| sclk | input | 1 | Serial-side clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write word address |
| wr_data | input | DATA_W | Register write data |
| rd_addr | input | ADDR_W | Register read word address |
| rd_data | output | DATA_W | Register read data (combinational) |
| nack_i | input | 1 | Datapath NACK condition |
| out_not_empty_i | input | 1 | Output FIFO not empty |
| in_not_empty_i | input | 1 | Input FIFO not empty |
| out_full_i | input | 1 | Output FIFO full |
| out_svc_evt_i | input | 1 | Output service event pulse |
| in_svc_evt_i | input | 1 | Input service event pulse |
| state_o | output | 2 | Current settled state code |
| run_en_o | output | 1 | Datapath run enable |
| pause_en_o | output | 1 | Datapath pause enable |

## Verification
The bench aims first at a software reset issued mid-transition and followed at once by a new request. A design that reused the stale acknowledge would report the new state settled far too early, or would never settle. Requests made while valid is low and writes of code 2 are aimed at designs that would restart or corrupt the exchange, which would show as a wrong final state or an early valid. Service flags are hit with an event and a clear in the same cycle, and with zero writes. A wrong priority or a plain write in place of write-one-to-clear would leave a flag in the wrong state.

// File: rtl/serial_run_pkg.sv
package serial_run_pkg;

    typedef enum logic [1:0] {
        ST_RESET = 2'd0,
        ST_RUN   = 2'd1,
        ST_PAUSE = 2'd3
    } run_state_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_WAIT,
        PH_XFER
    } xfer_phase_e;

    localparam int ADDR_STATE = 0;
    localparam int ADDR_SWRST = 1;
    localparam int ADDR_OPER  = 2;
    localparam int ADDR_MGEN  = 3;

    localparam int BIT_VALID  = 2;
    localparam int BIT_MREADY = 4;
    localparam int BIT_NACK   = 3;
    localparam int BIT_ONE    = 4;
    localparam int BIT_INE    = 5;
    localparam int BIT_OFULL  = 6;
    localparam int BIT_OSVC   = 8;
    localparam int BIT_ISVC   = 9;

    localparam logic [1:0] CODE_BAD = 2'd2;

endpackage

// File: rtl/rsc_sync2.sv
module rsc_sync2 (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic s1_q, s2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
        end else begin
            s1_q <= d;
            s2_q <= s1_q;
        end
    end

    assign q = s2_q;
endmodule

// File: rtl/rsc_serial_leg.sv
module rsc_serial_leg #(
    parameter int SER_CYC = 3
) (
    input  logic sclk,
    input  logic rst_n,
    input  logic req_tgl,
    output logic ack_tgl
);
    localparam int CNT_W = (SER_CYC > 1) ? $clog2(SER_CYC) : 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             ack;
    } leg_t;

    leg_t leg_d, leg_q;
    logic req_s;

    rsc_sync2 u_req_sync (
        .clk  (sclk),
        .rst_n(rst_n),
        .d    (req_tgl),
        .q    (req_s)
    );

    always_comb begin
        leg_d = leg_q;
        if (req_s != leg_q.ack) begin
            if (leg_q.cnt == CNT_W'(SER_CYC - 1)) begin
                leg_d.ack = req_s;
                leg_d.cnt = '0;
            end else begin
                leg_d.cnt = leg_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge sclk or negedge rst_n) begin
        if (!rst_n) leg_q <= '0;
        else        leg_q <= leg_d;
    end

    assign ack_tgl = leg_q.ack;

    // R3: the acknowledge only ever moves to the synchronised request value
    p_ack_follows_req_r3: assert property (@(posedge sclk) disable iff (!rst_n)
        (leg_q.ack != $past(leg_q.ack)) |-> (leg_q.ack == $past(req_s)));

    // R3: the acknowledge never moves before the serial-side count has run
    p_ack_waits_count_r3: assert property (@(posedge sclk) disable iff (!rst_n)
        (leg_q.ack != $past(leg_q.ack)) |-> ($past(leg_q.cnt) == CNT_W'(SER_CYC - 1)));
endmodule

// File: rtl/rsc_bus_ctrl.sv
module rsc_bus_ctrl
    import serial_run_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 32,
    parameter int BUS_CYC = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              nack_i,
    input  logic              out_not_empty_i,
    input  logic              in_not_empty_i,
    input  logic              out_full_i,
    input  logic              out_svc_evt_i,
    input  logic              in_svc_evt_i,
    input  logic              ack_sync,
    output logic              req_tgl,
    output run_state_e        state_o,
    output logic              valid_o,
    output logic              mready_o,
    output logic [DATA_W-1:0] oper_o
);
    localparam int CNT_W = (BUS_CYC > 1) ? $clog2(BUS_CYC) : 1;

    typedef struct packed {
        run_state_e       state;
        run_state_e       target;
        logic             valid;
        xfer_phase_e      phase;
        logic [CNT_W-1:0] cnt;
        logic             req;
        logic             mgen;
        logic             osvc;
        logic             isvc;
    } ctrl_t;

    ctrl_t c_d, c_q;

    logic wr_state, wr_swrst, wr_oper, wr_mgen;
    logic req_ok, swrst, link_idle;

    always_comb begin
        wr_state  = wr_en && (wr_addr == ADDR_W'(ADDR_STATE));
        wr_swrst  = wr_en && (wr_addr == ADDR_W'(ADDR_SWRST));
        wr_oper   = wr_en && (wr_addr == ADDR_W'(ADDR_OPER));
        wr_mgen   = wr_en && (wr_addr == ADDR_W'(ADDR_MGEN));
        swrst     = wr_swrst && wr_data[0];
        req_ok    = wr_state && (wr_data[1:0] != CODE_BAD) && c_q.valid;
        link_idle = (ack_sync == c_q.req);

        c_d = c_q;

        unique case (c_q.phase)
            PH_IDLE: begin
                if (req_ok) begin
                    c_d.target = run_state_e'(wr_data[1:0]);
                    c_d.valid  = 1'b0;
                    c_d.phase  = PH_WAIT;
                    c_d.cnt    = '0;
                end
            end
            PH_WAIT: begin
                if (c_q.cnt == CNT_W'(BUS_CYC - 1)) begin
                    if (link_idle) begin
                        c_d.req   = ~c_q.req;
                        c_d.phase = PH_XFER;
                    end
                end else begin
                    c_d.cnt = c_q.cnt + 1'b1;
                end
            end
            PH_XFER: begin
                if (link_idle) begin
                    c_d.state = c_q.target;
                    c_d.valid = 1'b1;
                    c_d.phase = PH_IDLE;
                end
            end
            default: c_d.phase = PH_IDLE;
        endcase

        if (wr_mgen) c_d.mgen = wr_data[0];

        c_d.osvc = (c_q.osvc & ~(wr_oper & wr_data[BIT_OSVC])) | out_svc_evt_i;
        c_d.isvc = (c_q.isvc & ~(wr_oper & wr_data[BIT_ISVC])) | in_svc_evt_i;

        if (swrst) begin
            c_d.state = ST_RESET;
            c_d.valid = 1'b1;
            c_d.phase = PH_IDLE;
            c_d.cnt   = '0;
            c_d.mgen  = 1'b0;
            c_d.osvc  = 1'b0;
            c_d.isvc  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q        <= '0;
            c_q.state  <= ST_RESET;
            c_q.target <= ST_RESET;
            c_q.valid  <= 1'b1;
            c_q.phase  <= PH_IDLE;
        end else begin
            c_q <= c_d;
        end
    end

    always_comb begin
        oper_o            = '0;
        oper_o[BIT_NACK]  = nack_i;
        oper_o[BIT_ONE]   = out_not_empty_i;
        oper_o[BIT_INE]   = in_not_empty_i;
        oper_o[BIT_OFULL] = out_full_i;
        oper_o[BIT_OSVC]  = c_q.osvc;
        oper_o[BIT_ISVC]  = c_q.isvc;
    end

    assign req_tgl  = c_q.req;
    assign state_o  = c_q.state;
    assign valid_o  = c_q.valid;
    assign mready_o = c_q.mgen;

    p_state_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.state != run_state_e'(CODE_BAD));

    p_valid_drops_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ok && !swrst) |=> !c_q.valid);

    p_state_holds_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!c_q.valid && !swrst) |=> (c_q.valid || $stable(c_q.state)));

    p_swrst_r4: assert property (@(posedge clk) disable iff (!rst_n)
        swrst |=> (c_q.state == ST_RESET) && c_q.valid && !c_q.mgen);

    p_osvc_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_oper && wr_data[BIT_OSVC] && !out_svc_evt_i) |=> !c_q.osvc);

    p_evt_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_svc_evt_i && !swrst) |=> c_q.isvc);

    p_code2_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_state && wr_data[1:0] == CODE_BAD && c_q.valid && !swrst)
            |=> ($stable(c_q.state) && c_q.valid));
endmodule

// File: rtl/serial_run_ctrl.sv
module serial_run_ctrl
    import serial_run_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 32,
    parameter int BUS_CYC = 3,
    parameter int SER_CYC = 3
) (
    input  logic              clk,
    input  logic              sclk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              nack_i,
    input  logic              out_not_empty_i,
    input  logic              in_not_empty_i,
    input  logic              out_full_i,
    input  logic              out_svc_evt_i,
    input  logic              in_svc_evt_i,
    output logic [1:0]        state_o,
    output logic              run_en_o,
    output logic              pause_en_o
);
    run_state_e        cur_state;
    logic              valid, mready, req_tgl, ack_tgl, ack_sync;
    logic [DATA_W-1:0] oper_word;

    rsc_bus_ctrl #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .BUS_CYC(BUS_CYC)
    ) u_bus (
        .clk            (clk),
        .rst_n          (rst_n),
        .wr_en          (wr_en),
        .wr_addr        (wr_addr),
        .wr_data        (wr_data),
        .nack_i         (nack_i),
        .out_not_empty_i(out_not_empty_i),
        .in_not_empty_i (in_not_empty_i),
        .out_full_i     (out_full_i),
        .out_svc_evt_i  (out_svc_evt_i),
        .in_svc_evt_i   (in_svc_evt_i),
        .ack_sync       (ack_sync),
        .req_tgl        (req_tgl),
        .state_o        (cur_state),
        .valid_o        (valid),
        .mready_o       (mready),
        .oper_o         (oper_word)
    );

    rsc_serial_leg #(
        .SER_CYC(SER_CYC)
    ) u_leg (
        .sclk   (sclk),
        .rst_n  (rst_n),
        .req_tgl(req_tgl),
        .ack_tgl(ack_tgl)
    );

    rsc_sync2 u_ack_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (ack_tgl),
        .q    (ack_sync)
    );

    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(ADDR_STATE)) begin
            rd_data[1:0]       = cur_state;
            rd_data[BIT_VALID]  = valid;
            rd_data[BIT_MREADY] = mready;
        end else if (rd_addr == ADDR_W'(ADDR_OPER)) begin
            rd_data = oper_word;
        end
    end

    assign state_o    = cur_state;
    assign run_en_o   = valid && (cur_state == ST_RUN);
    assign pause_en_o = valid && (cur_state == ST_PAUSE);

    p_en_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(run_en_o && pause_en_o));
endmodule

// File: tb/serial_run_ctrl_tb.sv
module serial_run_ctrl_tb;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 32;
    localparam int MINAGE = 10;
    localparam int MAXAGE = 80;

    logic clk = 1'b0, sclk = 1'b0, rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0, rd_addr = '0;
    logic [DATA_W-1:0] wr_data = '0, rd_data;
    logic nack_i = 0, one_i = 0, ine_i = 0, ofull_i = 0, osvc_evt = 0, isvc_evt = 0;
    logic [1:0] state_o;
    logic run_en_o, pause_en_o;

    always #10 clk = ~clk;
    always #35 sclk = ~sclk;

    serial_run_ctrl u_dut (
        .clk(clk), .sclk(sclk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .nack_i(nack_i), .out_not_empty_i(one_i), .in_not_empty_i(ine_i),
        .out_full_i(ofull_i), .out_svc_evt_i(osvc_evt), .in_svc_evt_i(isvc_evt),
        .state_o(state_o), .run_en_o(run_en_o), .pause_en_o(pause_en_o)
    );

    int checks = 0, errors = 0;
    bit model_on = 0, done = 0;
    // reference model
    int exp_state = 0, target = 0, age = 0;
    bit busy = 0, exp_mgen = 0, exp_osvc = 0, exp_isvc = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, expv, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (model_on && !done) begin
            if (busy) begin
                if (rd_addr == 0 && rd_data[2]) begin
                    chk(age >= MINAGE, "R3 settled too early", age, MINAGE);
                    chk(int'(rd_data[1:0]) == target, "R3 settled code", rd_data[1:0], target);
                    exp_state = target;
                    busy = 0;
                end else begin
                    chk(int'(state_o) == exp_state, "R3 field held", state_o, exp_state);
                    chk(age < MAXAGE, "R3 transition timeout", age, MAXAGE);
                    chk(!run_en_o && !pause_en_o, "R10 enables while busy", {run_en_o, pause_en_o}, 0);
                    age++;
                end
            end
            if (!busy) begin
                chk(int'(state_o) == exp_state, "R1 state", state_o, exp_state);
                if (rd_addr == 0) chk(rd_data[2] == 1'b1, "R2 valid settled", rd_data[2], 1);
                chk(run_en_o == (exp_state == 1), "R10 run enable", run_en_o, exp_state == 1);
                chk(pause_en_o == (exp_state == 3), "R10 pause enable", pause_en_o, exp_state == 3);
            end
        end
    end

    task automatic bus_wr(input int addr, input int data, input bit oe = 0, input bit ie = 0);
        @(negedge clk); #2;
        wr_en = 1; wr_addr = ADDR_W'(addr); wr_data = DATA_W'(data);
        osvc_evt = oe; isvc_evt = ie;
        @(posedge clk); #1;
        if (addr == 0 && data[1:0] != 2 && !busy) begin
            busy = 1; age = 0; target = data[1:0];
        end
        if (addr == 1 && data[0]) begin
            exp_state = 0; busy = 0; exp_mgen = 0; exp_osvc = 0; exp_isvc = 0;
        end
        if (addr == 3) exp_mgen = data[0];
        if (addr == 2 && data[8]) exp_osvc = 0;
        if (addr == 2 && data[9]) exp_isvc = 0;
        if (addr != 1 || !data[0]) begin
            if (oe) exp_osvc = 1;
            if (ie) exp_isvc = 1;
        end
        @(negedge clk); #2;
        wr_en = 0; osvc_evt = 0; isvc_evt = 0;
    endtask

    task automatic settle();
        for (int i = 0; i < 200 && busy; i++) @(negedge clk);
        #3;
    endtask

    task automatic rd_chk(input int addr, input int expv, input int mask, input string tag);
        @(negedge clk); #3;
        rd_addr = ADDR_W'(addr); #1;
        chk((int'(rd_data) & mask) == expv, tag, int'(rd_data) & mask, expv);
        rd_addr = '0;
    endtask

    function automatic int state_word();
        return (int'(exp_mgen) << 4) | 4 | exp_state;
    endfunction

    initial begin
        #100000000;
        errors++;
        $display("FAIL watchdog expired actual=hung expected=finish");
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk); #3;
        chk(rd_data == 32'h4, "R1 reset state word", rd_data, 32'h4);
        model_on = 1;

        bus_wr(0, 1); settle();                       // R2 R3: to run
        rd_chk(0, state_word(), 32'h17, "R1 run word");
        bus_wr(0, 3); settle();                       // R3: to pause
        rd_chk(0, state_word(), 32'h17, "R1 pause word");
        bus_wr(0, 2); repeat (6) @(negedge clk);      // R8: code 2 ignored
        rd_chk(0, state_word(), 32'h17, "R8 code 2 ignored");
        bus_wr(0, 0); settle();
        bus_wr(0, 1); repeat (3) @(negedge clk);
        bus_wr(0, 3); settle();                       // R9: dropped request
        rd_chk(0, 32'h5, 32'h17, "R9 dropped request");

        bus_wr(0, 3); repeat (8) @(negedge clk);
        bus_wr(1, 1);                                 // R4 mid-flight reset
        rd_chk(0, 32'h4, 32'h17, "R4 reset mid-flight");
        bus_wr(0, 1); settle();                       // R4 stale ack must not complete it
        rd_chk(0, 32'h5, 32'h17, "R4 request after reset");
        bus_wr(1, 0); repeat (2) @(negedge clk);
        rd_chk(0, 32'h5, 32'h17, "R4 zero write no effect");

        nack_i = 1; ofull_i = 1; #1;
        rd_chk(2, 32'h48, 32'h78, "R7 nack and full");
        nack_i = 0; ofull_i = 0; one_i = 1; ine_i = 1;
        rd_chk(2, 32'h30, 32'h78, "R7 not-empty flags");
        one_i = 0; ine_i = 0;

        bus_wr(3, 0, 1, 0);
        rd_chk(2, 32'h100, 32'h300, "R6 output service set");
        bus_wr(3, 0, 0, 1);
        rd_chk(2, 32'h300, 32'h300, "R6 input service set");
        bus_wr(2, 32'h100);
        rd_chk(2, 32'h200, 32'h300, "R6 w1c output");
        bus_wr(2, 0);
        rd_chk(2, 32'h200, 32'h300, "R6 zero write keeps");
        bus_wr(2, 32'h200, 0, 1);
        rd_chk(2, 32'h200, 32'h300, "R6 event beats clear");

        bus_wr(3, 1);
        rd_chk(0, 32'h15, 32'h17, "R5 master ready");
        bus_wr(0, 3); settle();
        rd_chk(0, state_word(), 32'h17, "R5 ready kept across change");
        bus_wr(1, 1);
        rd_chk(0, 32'h4, 32'h17, "R5 reset clears ready");
        rd_chk(2, 32'h0, 32'h300, "R4 reset clears flags");

        repeat (4) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule